// File: doc/BRIEF.md
# Missing Vertical Sync Watchdog with Panel AC-Drive Polarity

This block sits between the sync separator and the panel pulse generators of a liquid-crystal panel timing chain. It counts horizontal lines since the last vertical reset pulse. If a whole auxiliary frame passes without one (269 lines for the 525-line standard, 321 lines for the 625-line standard), it declares loss of signal. From then on the auxiliary line counter runs free and supplies the vertical reference pulse from which the vertical drive and vertical start pulses are built. While the signal is missing, the block also withdraws the output enable of the phase comparator, so that the frequency-control loop is not pulled by phase errors that mean nothing.

The block also generates the panel AC-drive polarity. In field-inversion mode the polarity flips at every vertical reference event, whether that event is a real vertical reset or a free-running wrap. In line-inversion mode it flips on every line tick. The polarity keeps toggling through the no-signal state, so the panel is always AC driven.

The control is a two-state machine. In `ST_LOCKED` the vertical sync is present. In `ST_FREERUN` the auxiliary counter drives the timing. The transitions are:
- **timeout**: `ST_LOCKED` to `ST_FREERUN`, taken on the terminal line tick when no vertical reset arrives in the same cycle.
- **reacquire**: `ST_FREERUN` to `ST_LOCKED`, taken on any vertical reset.
- **clear**: any state to `ST_FREERUN`, taken while the synchronous clear is low.

Top module: `nsw_ac_drive_ctrl`

## Requirements
- R1: After reset, and on the clock edge that follows a cycle with `clr_n` low, the outputs are `no_signal`=1, `pd_oe`=0, `frp`=0 and `vref_pulse`=0, and the line count restarts at zero. The clear takes priority over `line_tick` and `vreset` in the same cycle.
- R2: With `std_pal`=0, line ticks 1 to 268 after the last `vreset` leave `no_signal` low. The 269th tick sets `no_signal`=1 and `pd_oe`=0 on the next clock edge, and emits a one-cycle `vref_pulse` on that edge.
- R3: With `std_pal`=1, ticks 1 to 320 after the last `vreset` leave the block locked, and the 321st tick declares loss of signal.
- R4: A `vreset` sets `no_signal`=0 and `pd_oe`=1 on the next edge and emits a one-cycle `vref_pulse`. It also restarts the line count at zero, and a tick in the same cycle is not counted.
- R5: In the no-signal state, `vref_pulse` is high for exactly one cycle after every 269th tick (NTSC) or 321st tick (PAL) and is low after every other tick.
- R6: When `vreset` and the terminal line tick fall in the same cycle, the reset wins: the block stays locked and the count restarts.
- R7: If `std_pal` is lowered while the count is already at or beyond 268, the next tick is terminal.
- R8: With `inv_field`=0, `frp` inverts on the edge after each line tick and is not changed by `vreset`.
- R9: With `inv_field`=1, `frp` inverts on the edge after each vertical reference event (a `vreset` or a terminal tick) and is not changed by other ticks.
- R10: `frp` keeps inverting in the no-signal state in both inversion modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low clear into the no-signal state |
| line_tick | input | 1 | One-cycle strobe, once per horizontal line |
| vreset | input | 1 | One-cycle vertical reset pulse from the sync separator |
| std_pal | input | 1 | 1 = 625-line standard (321-line timeout), 0 = 525-line standard (269-line timeout) |
| inv_field | input | 1 | 1 = field inversion, 0 = line inversion |
| vref_pulse | output | 1 | One-cycle vertical reference for the vertical drive and start pulses |
| no_signal | output | 1 | High while vertical sync is missing |
| pd_oe | output | 1 | Phase-comparator output enable (0 = high impedance) |
| frp | output | 1 | AC-drive polarity |

## Verification
Two functions can meet in one cycle: a vertical reset that restarts the count, and the terminal line tick that would declare a timeout. The bench provokes this by issuing exactly 268 ticks after a reset and then driving `vreset` and `line_tick` in the same cycle. It then judges that the block stays locked with a reference pulse, and that only the 269th tick counted from that cycle times out. The same edge is exercised for the clear: driving `clr_n` low together with `vreset` and a tick must leave the block in the no-signal state with `frp` at zero.

// File: rtl/nsw_pkg.sv
package nsw_pkg;

    typedef enum logic {
        ST_LOCKED  = 1'b0,
        ST_FREERUN = 1'b1
    } nsw_state_e;

endpackage

// File: rtl/nsw_line_counter.sv
module nsw_line_counter #(
    parameter int NTSC_LINES = 269,
    parameter int PAL_LINES  = 321
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic line_tick,
    input  logic vreset,
    input  logic std_pal,
    output logic terminal
);

    localparam int MAX_LINES = (NTSC_LINES > PAL_LINES) ? NTSC_LINES : PAL_LINES;
    localparam int CNT_W     = $clog2(MAX_LINES + 1);
    localparam logic [CNT_W-1:0] NTSC_LAST = CNT_W'(NTSC_LINES - 1);
    localparam logic [CNT_W-1:0] PAL_LAST  = CNT_W'(PAL_LINES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_line;

    assign last_line = std_pal ? PAL_LAST : NTSC_LAST;
    assign terminal  = line_tick && (cnt_q >= last_line);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!clr_n || vreset) begin
            cnt_q <= '0;
        end else if (line_tick) begin
            cnt_q <= terminal ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/nsw_sync_fsm.sv
module nsw_sync_fsm
    import nsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic vreset,
    input  logic terminal,
    output logic field_evt,
    output logic vref_pulse,
    output logic no_signal,
    output logic pd_oe
);

    nsw_state_e state_q;
    nsw_state_e state_nx;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (!vreset && terminal) begin
                    state_nx = ST_FREERUN;
                end
            end
            ST_FREERUN: begin
                if (vreset) begin
                    state_nx = ST_LOCKED;
                end
            end
        endcase
        if (!clr_n) begin
            state_nx = ST_FREERUN;
        end
    end

    assign field_evt = clr_n && (vreset || terminal);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREERUN;
        end else begin
            state_q <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vref_pulse <= 1'b0;
            no_signal  <= 1'b1;
            pd_oe      <= 1'b0;
        end else begin
            vref_pulse <= field_evt;
            no_signal  <= (state_nx == ST_FREERUN);
            pd_oe      <= (state_nx == ST_LOCKED);
        end
    end

endmodule

// File: rtl/nsw_polarity.sv
module nsw_polarity (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic inv_field,
    input  logic line_tick,
    input  logic field_evt,
    output logic frp
);

    logic flip;

    assign flip = inv_field ? field_evt : line_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frp <= 1'b0;
        end else if (!clr_n) begin
            frp <= 1'b0;
        end else if (flip) begin
            frp <= ~frp;
        end
    end

endmodule

// File: rtl/nsw_ac_drive_ctrl.sv
module nsw_ac_drive_ctrl #(
    parameter int NTSC_LINES = 269,
    parameter int PAL_LINES  = 321
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic line_tick,
    input  logic vreset,
    input  logic std_pal,
    input  logic inv_field,
    output logic vref_pulse,
    output logic no_signal,
    output logic pd_oe,
    output logic frp
);

    logic terminal;
    logic field_evt;

    nsw_line_counter #(
        .NTSC_LINES(NTSC_LINES),
        .PAL_LINES (PAL_LINES)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .line_tick(line_tick),
        .vreset   (vreset),
        .std_pal  (std_pal),
        .terminal (terminal)
    );

    nsw_sync_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .vreset    (vreset),
        .terminal  (terminal),
        .field_evt (field_evt),
        .vref_pulse(vref_pulse),
        .no_signal (no_signal),
        .pd_oe     (pd_oe)
    );

    nsw_polarity pol_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .inv_field(inv_field),
        .line_tick(line_tick),
        .field_evt(field_evt),
        .frp      (frp)
    );

endmodule

// File: rtl/nsw_ac_drive_chk.sv
module nsw_ac_drive_chk #(
    parameter int NTSC_LINES = 269,
    parameter int PAL_LINES  = 321
) (
    input logic clk,
    input logic rst_n,
    input logic clr_n,
    input logic line_tick,
    input logic vreset,
    input logic std_pal,
    input logic inv_field,
    input logic vref_pulse,
    input logic no_signal,
    input logic pd_oe,
    input logic frp
);

    int lines_seen;
    int last_idx;
    logic at_limit;

    assign last_idx = std_pal ? (PAL_LINES - 1) : (NTSC_LINES - 1);
    assign at_limit = line_tick && (lines_seen >= last_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines_seen <= 0;
        end else if (!clr_n || vreset) begin
            lines_seen <= 0;
        end else if (line_tick) begin
            lines_seen <= at_limit ? 0 : lines_seen + 1;
        end
    end

    // R1: clear forces the no-signal state with the polarity low
    a_r1_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (no_signal && !pd_oe && !frp && !vref_pulse));

    // R2, R3: a full auxiliary period without vertical reset times out
    a_r2_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !vreset && at_limit) |=> (no_signal && !pd_oe && vref_pulse));

    // R2, R3: no early timeout while locked
    a_r3_no_early_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !vreset && !no_signal && !at_limit) |=> !no_signal);

    // R4, R6: vertical reset reacquires lock with a reference pulse
    a_r4_reacquire: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && vreset) |=> (!no_signal && pd_oe && vref_pulse));

    // R8: line inversion toggles per tick
    a_r8_line_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !inv_field && line_tick) |=> (frp != $past(frp)));

    // R9: field inversion ignores non-terminal ticks
    a_r9_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && inv_field && !vreset && !at_limit) |=> $stable(frp));

endmodule

bind nsw_ac_drive_ctrl nsw_ac_drive_chk #(
    .NTSC_LINES(NTSC_LINES),
    .PAL_LINES (PAL_LINES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .line_tick (line_tick),
    .vreset    (vreset),
    .std_pal   (std_pal),
    .inv_field (inv_field),
    .vref_pulse(vref_pulse),
    .no_signal (no_signal),
    .pd_oe     (pd_oe),
    .frp       (frp)
);

// File: tb/nsw_ac_drive_ctrl_tb_top.sv
`timescale 1ns/1ps
module nsw_ac_drive_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_n = 1'b1;
    logic line_tick = 1'b0;
    logic vreset = 1'b0;
    logic std_pal = 1'b0;
    logic inv_field = 1'b0;
    logic vref_pulse, no_signal, pd_oe, frp;

    int n_cmp = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    nsw_ac_drive_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .line_tick (line_tick),
        .vreset    (vreset),
        .std_pal   (std_pal),
        .inv_field (inv_field),
        .vref_pulse(vref_pulse),
        .no_signal (no_signal),
        .pd_oe     (pd_oe),
        .frp       (frp)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic lt, input logic vr);
        line_tick = lt;
        vreset    = vr;
        @(posedge clk);
        #1;
        line_tick = 1'b0;
        vreset    = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0);
            cyc(1'b0, 1'b0);
        end
    endtask

    task automatic t_reset();
        chk("R1 reset no_signal", no_signal, 1);
        chk("R1 reset pd_oe", pd_oe, 0);
        chk("R1 reset frp", frp, 0);
        chk("R1 reset vref", vref_pulse, 0);
    endtask

    task automatic t_ntsc_timeout();
        std_pal = 1'b0;
        inv_field = 1'b0;
        cyc(1'b0, 1'b1);
        chk("R4 lock no_signal", no_signal, 0);
        chk("R4 lock pd_oe", pd_oe, 1);
        chk("R4 lock vref", vref_pulse, 1);
        cyc(1'b0, 1'b0);
        chk("R4 vref one cycle", vref_pulse, 0);
        ticks(268);
        chk("R2 still locked at 268", no_signal, 0);
        cyc(1'b1, 1'b0);
        chk("R2 timeout no_signal", no_signal, 1);
        chk("R2 timeout pd_oe", pd_oe, 0);
        chk("R2 timeout vref", vref_pulse, 1);
        cyc(1'b0, 1'b0);
    endtask

    task automatic t_freerun();
        int pulses = 0;
        int where = -1;
        for (int i = 0; i < 269; i++) begin
            cyc(1'b1, 1'b0);
            if (vref_pulse) begin
                pulses++;
                where = i;
            end
            cyc(1'b0, 1'b0);
            if (vref_pulse) pulses += 100;
        end
        chk("R5 freerun pulse count", pulses, 1);
        chk("R5 freerun pulse position", where, 268);
        chk("R5 still no_signal", no_signal, 1);
    endtask

    task automatic t_pal_timeout();
        std_pal = 1'b1;
        cyc(1'b0, 1'b1);
        ticks(320);
        chk("R3 still locked at 320", no_signal, 0);
        cyc(1'b1, 1'b0);
        chk("R3 timeout no_signal", no_signal, 1);
        chk("R3 timeout pd_oe", pd_oe, 0);
        cyc(1'b0, 1'b0);
    endtask

    task automatic t_coincide();
        std_pal = 1'b0;
        cyc(1'b0, 1'b1);
        ticks(268);
        cyc(1'b1, 1'b1);
        chk("R6 coincide no_signal", no_signal, 0);
        chk("R6 coincide vref", vref_pulse, 1);
        cyc(1'b0, 1'b0);
        ticks(268);
        chk("R6 tick not counted", no_signal, 0);
        cyc(1'b1, 1'b0);
        chk("R6 timeout after restart", no_signal, 1);
        cyc(1'b0, 1'b0);
    endtask

    task automatic t_std_switch();
        std_pal = 1'b1;
        cyc(1'b0, 1'b1);
        ticks(300);
        chk("R7 locked at 300 in PAL", no_signal, 0);
        std_pal = 1'b0;
        cyc(1'b1, 1'b0);
        chk("R7 switch to NTSC times out", no_signal, 1);
        cyc(1'b0, 1'b0);
    endtask

    task automatic t_frp_line();
        logic f;
        inv_field = 1'b0;
        f = frp;
        cyc(1'b1, 1'b0);
        chk("R8 R10 line flip in no-signal", frp, !f);
        cyc(1'b0, 1'b0);
        chk("R8 hold without tick", frp, !f);
        cyc(1'b0, 1'b1);
        chk("R8 vreset ignored", frp, !f);
        cyc(1'b1, 1'b0);
        chk("R8 line flip locked", frp, f);
        cyc(1'b0, 1'b0);
    endtask

    task automatic t_frp_field();
        logic f;
        std_pal = 1'b0;
        inv_field = 1'b1;
        cyc(1'b0, 1'b1);
        f = frp;
        ticks(5);
        chk("R9 ticks ignored", frp, f);
        cyc(1'b0, 1'b1);
        chk("R9 vreset flips", frp, !f);
        ticks(268);
        chk("R9 hold through field", frp, !f);
        cyc(1'b1, 1'b0);
        chk("R9 timeout flips", frp, f);
        ticks(268);
        chk("R10 hold in freerun field", frp, f);
        cyc(1'b1, 1'b0);
        chk("R10 freerun wrap flips", frp, !f);
        cyc(1'b0, 1'b0);
    endtask

    task automatic t_clear();
        int pulses = 0;
        inv_field = 1'b0;
        std_pal = 1'b0;
        cyc(1'b0, 1'b1);
        if (frp == 1'b0) cyc(1'b1, 1'b0);
        chk("R1 precondition frp high", frp, 1);
        clr_n = 1'b0;
        cyc(1'b1, 1'b1);
        clr_n = 1'b1;
        chk("R1 clear no_signal", no_signal, 1);
        chk("R1 clear pd_oe", pd_oe, 0);
        chk("R1 clear frp", frp, 0);
        chk("R1 clear vref", vref_pulse, 0);
        for (int i = 0; i < 268; i++) begin
            cyc(1'b1, 1'b0);
            if (vref_pulse) pulses++;
            cyc(1'b0, 1'b0);
        end
        chk("R1 count restarted by clear", pulses, 0);
        cyc(1'b1, 1'b0);
        chk("R1 R5 first wrap after clear", vref_pulse, 1);
        cyc(1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_ntsc_timeout();
        t_freerun();
        t_pal_timeout();
        t_coincide();
        t_std_switch();
        t_frp_line();
        t_frp_field();
        t_clear();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule